// File: doc/BRIEF.md
# Triggered Serial Pixel-Array Readout Sequencer

This block empties a square array of pixel time-to-digital converters over a single serial line. Each pixel holds an 8-bit result, a 4-bit coarse count in the upper nibble and a 4-bit fine count in the lower nibble. When the read trigger is seen while the sequencer is idle, the block takes a snapshot of every pixel word and streams the words one bit per slow-clock cycle. During the snapshot, any pixel flagged by its mask bit is replaced with zeros. While the bits go out, a frame marker is held high. One cycle after the last bit, the block pulses a reset to the pixel array.

The sequencer has three named states. In `ST_IDLE` it waits for a trigger. In `ST_SHIFT` it shifts out the frame. In `ST_CLEAR` it drives the array reset for one cycle. The transitions are:

- idle-to-shift, taken on a trigger;
- shift-to-clear, taken after the last bit;
- clear-to-idle, which is unconditional.

The trigger is only examined in `ST_IDLE`.

Top module: `pixrd_seq`

## Requirements
- R1: After reset, `frame_o`, `arr_reset_o` and `sdata_o` are all low.
- R2: When `read_i` is high at a clock edge while idle, `frame_o` rises after that edge and stays high for exactly 2048 consecutive cycles.
- R3: The frame carries pixels in ascending index, from 0 to 255. Pixel p's word is taken from `codes_i[p*8 +: 8]`, with bits 7:4 coarse and 3:0 fine. Each word is sent most significant bit first, one bit per cycle.
- R4: A pixel whose `mask_i[p]` is 1 contributes eight zero bits.
- R5: `codes_i` and `mask_i` are sampled at the trigger edge. Changing them during a frame has no effect on that frame.
- R6: `read_i` is ignored while a frame is in progress and during the array-reset cycle. No frame is lengthened and no second frame is started.
- R7: In the cycle after the last frame bit, `arr_reset_o` is high for exactly one cycle while `frame_o` is low. The block is then idle.
- R8: `sdata_o` is low whenever `frame_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow readout clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| read_i | input | 1 | Read trigger |
| mask_i | input | 256 | Per-pixel disable, 1 = masked |
| codes_i | input | 2048 | Pixel words, pixel p at bits p*8+7..p*8 |
| sdata_o | output | 1 | Serial frame data |
| frame_o | output | 1 | High while frame bits are valid |
| arr_reset_o | output | 1 | One-cycle pixel array reset |

## Verification
The bench compares every one of the 2048 bits of each frame against a model built from the pixel words. This catches a reversed bit order inside a word, a reversed pixel order, and a mask that is inverted or applied to the wrong pixel. Pixels 0 and 255 are masked to probe both ends of the stream. Mid-frame trigger pulses, together with changes to the live pixel data, expose two faults: a design that restarts or stretches the frame, and one that reads pixel data live instead of from the snapshot. The bench also checks the frame length and the reset pulse width. These catch an off-by-one bit counter and a reset that lasts two cycles or overlaps the frame.

// File: rtl/pixrd_pkg.sv
package pixrd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_CLEAR = 2'd2
    } seq_state_t;
endpackage

// File: rtl/pixrd_fsm.sv
module pixrd_fsm
    import pixrd_pkg::*;
#(
    parameter int TOTAL_BITS = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       read_i,
    output seq_state_t state_o,
    output logic       load_o,
    output logic       shift_o,
    output logic       frame_o,
    output logic       arr_reset_o
);
    localparam int CNT_W = $clog2(TOTAL_BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL_BITS - 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (read_i) state_d = ST_SHIFT;
            ST_SHIFT: if (cnt_q == LAST) state_d = ST_CLEAR;
            ST_CLEAR: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SHIFT) cnt_q <= cnt_q + 1'b1;
            else                     cnt_q <= '0;
        end
    end

    always_comb begin
        load_o      = 1'b0;
        shift_o     = 1'b0;
        frame_o     = 1'b0;
        arr_reset_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  load_o = read_i;
            ST_SHIFT: begin
                shift_o = 1'b1;
                frame_o = 1'b1;
            end
            ST_CLEAR: arr_reset_o = 1'b1;
            default:  ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/pixrd_loader.sv
module pixrd_loader #(
    parameter int NPIX   = 256,
    parameter int WORD_W = 8
) (
    input  logic [NPIX-1:0]        mask_i,
    input  logic [NPIX*WORD_W-1:0] codes_i,
    output logic [NPIX*WORD_W-1:0] frame_vec_o
);
    // pixel 0 lands in the top word so it leaves first
    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        assign frame_vec_o[(NPIX-1-p)*WORD_W +: WORD_W] =
            mask_i[p] ? '0 : codes_i[p*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/pixrd_shifter.sv
module pixrd_shifter #(
    parameter int WIDTH = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic [WIDTH-1:0] data_i,
    output logic             bit_o
);
    logic [WIDTH-1:0] sreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sreg_q <= '0;
        else if (load_i)  sreg_q <= data_i;
        else if (shift_i) sreg_q <= {sreg_q[WIDTH-2:0], 1'b0};
    end

    assign bit_o = sreg_q[WIDTH-1];
endmodule

// File: rtl/pixrd_seq.sv
module pixrd_seq
    import pixrd_pkg::*;
#(
    parameter int ROWS   = 16,
    parameter int COLS   = 16,
    parameter int WORD_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        read_i,
    input  logic [ROWS*COLS-1:0]        mask_i,
    input  logic [ROWS*COLS*WORD_W-1:0] codes_i,
    output logic                        sdata_o,
    output logic                        frame_o,
    output logic                        arr_reset_o
);
    localparam int NPIX       = ROWS * COLS;
    localparam int TOTAL_BITS = NPIX * WORD_W;

    seq_state_t            state;
    logic                  load, shift;
    logic [TOTAL_BITS-1:0] frame_vec;

    pixrd_fsm #(.TOTAL_BITS(TOTAL_BITS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .read_i      (read_i),
        .state_o     (state),
        .load_o      (load),
        .shift_o     (shift),
        .frame_o     (frame_o),
        .arr_reset_o (arr_reset_o)
    );

    pixrd_loader #(.NPIX(NPIX), .WORD_W(WORD_W)) u_loader (
        .mask_i      (mask_i),
        .codes_i     (codes_i),
        .frame_vec_o (frame_vec)
    );

    pixrd_shifter #(.WIDTH(TOTAL_BITS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .shift_i (shift),
        .data_i  (frame_vec),
        .bit_o   (sdata_o)
    );
endmodule

// File: rtl/pixrd_seq_chk.sv
module pixrd_seq_chk #(
    parameter int TOTAL_BITS = 2048
) (
    input logic clk,
    input logic rst_n,
    input logic read_i,
    input logic sdata_o,
    input logic frame_o,
    input logic arr_reset_o
);
    localparam int CW = $clog2(TOTAL_BITS + 1) + 1;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_q <= '0;
        else if (frame_o) run_q <= run_q + 1'b1;
        else              run_q <= '0;
    end

    // R2
    frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (read_i && !frame_o && !arr_reset_o) |=> frame_o);

    // R2
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_o) |-> (run_q == CW'(TOTAL_BITS)));

    // R2
    frame_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= CW'(TOTAL_BITS));

    // R7
    clear_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_o) |-> arr_reset_o);

    // R7
    clear_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_reset_o |=> !arr_reset_o);

    // R7
    clear_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_reset_o |-> !frame_o);

    // R6
    clear_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_reset_o |=> !frame_o);

    // R8
    quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_o |-> !sdata_o);
endmodule

bind pixrd_seq pixrd_seq_chk #(.TOTAL_BITS(ROWS*COLS*WORD_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .read_i      (read_i),
    .sdata_o     (sdata_o),
    .frame_o     (frame_o),
    .arr_reset_o (arr_reset_o)
);

// File: tb/test_pixrd_seq.sv
`timescale 1ns/1ps
module test_pixrd_seq;
    localparam int NPIX  = 256;
    localparam int NBITS = 2048;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              read_i = 1'b0;
    logic [NPIX-1:0]   mask_i;
    logic [NBITS-1:0]  codes_i;
    logic              sdata_o, frame_o, arr_reset_o;

    logic [7:0] tb_code [NPIX];
    logic       exp_bit [NBITS];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int p = 0; p < NPIX; p++) codes_i[p*8 +: 8] = tb_code[p];
    end

    pixrd_seq i_pixrd_seq (
        .clk(clk), .rst_n(rst_n), .read_i(read_i), .mask_i(mask_i),
        .codes_i(codes_i), .sdata_o(sdata_o), .frame_o(frame_o),
        .arr_reset_o(arr_reset_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic build_expected();
        for (int p = 0; p < NPIX; p++)
            for (int b = 0; b < 8; b++)
                exp_bit[p*8 + b] = mask_i[p] ? 1'b0 : tb_code[p][7-b];
    endtask

    // disturb: 0 none, 1 mid-frame read pulses plus data/mask changes
    task automatic run_frame(input string req, input int disturb);
        int bad_pos = -1;
        int frame_len = 0;
        build_expected();
        @(negedge clk) read_i = 1'b1;
        @(negedge clk) read_i = 1'b0;
        for (int k = 0; k < NBITS; k++) begin
            if (frame_o) frame_len++;
            if (sdata_o !== exp_bit[k] && bad_pos < 0) bad_pos = k;
            if (disturb == 1) begin
                if (k == 300) begin
                    read_i = 1'b1;
                    for (int p = 0; p < NPIX; p++) tb_code[p] = ~tb_code[p];
                    mask_i = ~mask_i;
                end
                if (k == 305) read_i = 1'b0;
                if (k == NBITS-1) read_i = 1'b1;
            end
            @(negedge clk);
        end
        chk(frame_len == NBITS, "R2 frame length", frame_len, NBITS);
        chk(bad_pos < 0, {req, " first bad bit index"}, bad_pos, -1);
        chk(!frame_o && arr_reset_o, "R7 reset pulse after frame",
            {frame_o, arr_reset_o}, 1);
        @(negedge clk);
        read_i = 1'b0;
        chk(!frame_o && !arr_reset_o, "R7/R6 idle after reset pulse",
            {frame_o, arr_reset_o}, 0);
        chk(!sdata_o, "R8 line low after frame", sdata_o, 0);
        repeat (3) @(negedge clk);
        chk(!frame_o, "R6 no new frame from ignored read", frame_o, 0);
    endtask

    task automatic t_reset();
        chk(!frame_o && !arr_reset_o && !sdata_o, "R1 reset outputs",
            {frame_o, arr_reset_o, sdata_o}, 0);
    endtask

    task automatic t_plain();
        mask_i = '0;
        for (int p = 0; p < NPIX; p++) tb_code[p] = 8'(p) ^ 8'h5A;
        run_frame("R3 ascending order MSB first", 0);
    endtask

    task automatic t_single_pixel();
        mask_i = '0;
        for (int p = 0; p < NPIX; p++) tb_code[p] = 8'h00;
        tb_code[1] = 8'h81;
        tb_code[254] = 8'hC3;
        run_frame("R3 isolated words", 0);
    endtask

    task automatic t_mask();
        for (int p = 0; p < NPIX; p++) begin
            tb_code[p] = 8'hFF - 8'(p);
            mask_i[p] = (p % 3 == 0) || (p == 255);
        end
        run_frame("R4 masked pixels zero", 0);
    endtask

    task automatic t_disturb();
        for (int p = 0; p < NPIX; p++) begin
            tb_code[p] = {4'(p >> 4), 4'(p)};
            mask_i[p] = (p % 7 == 2);
        end
        run_frame("R5 snapshot frozen", 1);
    endtask

    initial begin
        mask_i = '0;
        for (int p = 0; p < NPIX; p++) tb_code[p] = '1;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_plain();
        t_single_pixel();
        t_mask();
        t_disturb();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (60000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule